// File: doc/BRIEF.md
# Receiver Multi-Region Reset Sequencer

This controller drives the reset lines of four receiver sub-blocks: the analog front-end interface, the data-path interface, the elastic-buffer bypass logic and the PCS. A global receive reset pulse starts a run. When the pulse is released, the controller captures the mode, the two region masks and the bypass enable. It then either walks the selected regions one at a time or resets them all together. The PCS reset is never released until the application reports that its clocks are stable through the user-ready input.

In sequential mode, completion is reported on a done output. In single mode, done stays low, and five direct component reset inputs are passed straight through to their components. Each region is held in reset for a fixed number of cycles, set by the `HOLD_CYCLES` parameter. A region that is masked off costs no cycles at all.

Top module: `rx_rst_seq`

## Requirements
- R1: While `rstN` is low, `regRst` and `done` are all zero, and they remain zero afterwards until a run starts.
- R2: `regRst` bit 0 is the front-end, bit 1 the data-path interface, bit 2 the buffer bypass logic and bit 3 the PCS. `feMask` bit 0 selects the front-end and bit 1 the data-path interface. `pcsMask` bit 0 selects the bypass logic and bit 1 the PCS. A region whose bit is low is never put in reset.
- R3: In sequential mode (`seqMode`=1), the selected regions are reset one at a time in ascending bit order. Each is asserted for `HOLD_CYCLES` cycles. The first assertion appears right after the clock edge that samples `gblRst` low following a pulse, and each release coincides with the next region's assertion.
- R4: An unselected region in the sequential walk takes zero cycles.
- R5: In single mode (`seqMode`=0), all selected regions assert together right after the start edge and hold for `HOLD_CYCLES` cycles.
- R6: In both modes, the PCS reset is released only on an edge where `userRdy` is high. It remains asserted beyond its hold until that happens.
- R7: In sequential mode, `done` rises in the same cycle as the last release (or right after the start edge if no region is selected) and stays high until the next `gblRst`. In single mode, `done` never asserts.
- R8: Any edge that samples `gblRst` high aborts the run: from the next cycle, all `regRst` bits are low and `done` is low. Releasing `gblRst` restarts from the first selected region.
- R9: Mode, masks and bypass enable are captured at the start edge. Changes made to them during a run have no effect on that run.
- R10: `compRst` equals `dirRst` while `seqMode` is 0 and is all zero while `seqMode` is 1. The bit order is eye-scan, out-of-band, clock-data recovery, PRBS counter, auxiliary PCS path.
- R11: The bypass region takes part only if `bypEn` is high at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gblRst | input | 1 | Global receive reset; its release starts a run |
| seqMode | input | 1 | 1 = sequential walk, 0 = all regions together |
| feMask | input | 2 | Front-end region selection |
| pcsMask | input | 2 | Bypass / PCS region selection |
| bypEn | input | 1 | Buffer bypass in use |
| userRdy | input | 1 | Application clocks stable; gates the PCS release |
| dirRst | input | 5 | Direct component reset requests |
| regRst | output | 4 | Region reset outputs |
| compRst | output | 5 | Direct component reset outputs |
| done | output | 1 | Sequential run complete |

## Verification
Count cycles from the start edge, meaning the first edge that samples `gblRst` low after a pulse. The `regRst` and `done` outputs are registered, so their values in cycle t are already visible after edge t. Region k in the walk is asserted from cycle k·H to cycle (k+1)·H−1. The PCS release edge is the later of its hold expiry and one edge past the cycle in which `userRdy` is raised. `compRst` is combinational and is due in the same cycle as its inputs. The bench computes these windows in a function and compares every output on the falling clock edge of every cycle, including the cycle right after an abort.

// File: rtl/rx_rst_pkg.sv
package rx_rst_pkg;
  localparam int unsigned NUM_REGIONS = 4;
  localparam int unsigned NUM_DIRECT  = 5;
  localparam int unsigned IDX_W       = $clog2(NUM_REGIONS);
  localparam int unsigned SRCH_W      = IDX_W + 1;
  localparam int unsigned PCS_IDX     = NUM_REGIONS - 1;

  typedef struct packed {
    logic cfgLoad;   // capture configuration and load the hold counter
    logic cntLoad;   // reload the hold counter for the next region
  } dpStrobe_t;

  // Lowest set bit of sel at or above index from; NUM_REGIONS when none.
  function automatic logic [SRCH_W-1:0] firstFrom(logic [NUM_REGIONS-1:0] sel,
                                                  logic [SRCH_W-1:0] from);
    logic [SRCH_W-1:0] res;
    res = SRCH_W'(NUM_REGIONS);
    for (int k = NUM_REGIONS - 1; k >= 0; k--) begin
      if (sel[k] && (SRCH_W'(k) >= from)) res = SRCH_W'(k);
    end
    return res;
  endfunction
endpackage

// File: rtl/rx_rst_dp.sv
module rx_rst_dp
  import rx_rst_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  input  logic                   seqMode,
  input  logic [1:0]             feMask,
  input  logic [1:0]             pcsMask,
  input  logic                   bypEn,
  input  logic [NUM_DIRECT-1:0]  dirRst,
  output logic [NUM_REGIONS-1:0] liveSel,
  output logic [NUM_REGIONS-1:0] latSel,
  output logic                   seqLat,
  output logic                   holdDone,
  output logic [NUM_DIRECT-1:0]  compRst
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign liveSel  = {pcsMask[1], pcsMask[0] & bypEn, feMask[1], feMask[0]};
  assign holdDone = (cnt == '0);
  assign compRst  = seqMode ? '0 : dirRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latSel <= '0;
      seqLat <= 1'b0;
    end else if (strb.cfgLoad) begin
      latSel <= liveSel;
      seqLat <= seqMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           cnt <= '0;
    else if (strb.cfgLoad || strb.cntLoad) cnt <= CNT_INIT;
    else if (cnt != '0)                  cnt <= cnt - 1'b1;
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgLoad |=> ($stable(latSel) && $stable(seqLat)));
endmodule

// File: rtl/rx_rst_ctrl.sv
module rx_rst_ctrl
  import rx_rst_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   gblRst,
  input  logic                   seqMode,
  input  logic                   userRdy,
  input  logic [NUM_REGIONS-1:0] liveSel,
  input  logic [NUM_REGIONS-1:0] latSel,
  input  logic                   seqLat,
  input  logic                   holdDone,
  output dpStrobe_t              strb,
  output logic [NUM_REGIONS-1:0] regRst,
  output logic                   done
);
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_SEQ, ST_ALL} state_t;

  state_t st, stN;
  logic [IDX_W-1:0] cur, curN;
  logic [NUM_REGIONS-1:0] regN;
  logic doneN;
  logic [SRCH_W-1:0] firstLive, nextLat;

  assign firstLive = firstFrom(liveSel, '0);
  assign nextLat   = firstFrom(latSel, SRCH_W'(cur) + 1'b1);

  always_comb begin
    stN   = st;
    curN  = cur;
    regN  = regRst;
    doneN = done;
    strb  = '0;
    if (gblRst) begin
      stN   = ST_ARM;
      regN  = '0;
      doneN = 1'b0;
    end else begin
      unique case (st)
        ST_ARM: begin
          strb.cfgLoad = 1'b1;
          if (seqMode) begin
            if (firstLive[IDX_W]) begin
              doneN = 1'b1;
              stN   = ST_IDLE;
            end else begin
              regN = '0;
              regN[firstLive[IDX_W-1:0]] = 1'b1;
              curN = firstLive[IDX_W-1:0];
              stN  = ST_SEQ;
            end
          end else begin
            regN = liveSel;
            stN  = (liveSel == '0) ? ST_IDLE : ST_ALL;
          end
        end
        ST_SEQ: begin
          if (holdDone && ((cur != IDX_W'(PCS_IDX)) || userRdy)) begin
            regN = '0;
            if (nextLat[IDX_W]) begin
              doneN = 1'b1;
              stN   = ST_IDLE;
            end else begin
              regN[nextLat[IDX_W-1:0]] = 1'b1;
              curN = nextLat[IDX_W-1:0];
              strb.cntLoad = 1'b1;
            end
          end
        end
        ST_ALL: begin
          if (holdDone) begin
            regN = '0;
            regN[PCS_IDX] = regRst[PCS_IDX] & ~userRdy;
            if (regN == '0) stN = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      cur    <= '0;
      regRst <= '0;
      done   <= 1'b0;
    end else begin
      st     <= stN;
      cur    <= curN;
      regRst <= regN;
      done   <= doneN;
    end
  end

  // R8
  gbl_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    gblRst |=> ((regRst == '0) && !done));

  // R3
  seq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SEQ) |-> ($countones(regRst) == 1));

  // R6
  pcs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(regRst[PCS_IDX]) && !$past(gblRst)) |-> $past(userRdy));

  // R7
  done_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> seqLat);
endmodule

// File: rtl/rx_rst_seq.sv
module rx_rst_seq
  import rx_rst_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   gblRst,
  input  logic                   seqMode,
  input  logic [1:0]             feMask,
  input  logic [1:0]             pcsMask,
  input  logic                   bypEn,
  input  logic                   userRdy,
  input  logic [NUM_DIRECT-1:0]  dirRst,
  output logic [NUM_REGIONS-1:0] regRst,
  output logic [NUM_DIRECT-1:0]  compRst,
  output logic                   done
);
  dpStrobe_t strb;
  logic [NUM_REGIONS-1:0] liveSel, latSel;
  logic seqLat, holdDone;

  rx_rst_dp #(.HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .seqMode(seqMode),
    .feMask(feMask), .pcsMask(pcsMask), .bypEn(bypEn), .dirRst(dirRst),
    .liveSel(liveSel), .latSel(latSel), .seqLat(seqLat),
    .holdDone(holdDone), .compRst(compRst)
  );

  rx_rst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .gblRst(gblRst), .seqMode(seqMode),
    .userRdy(userRdy), .liveSel(liveSel), .latSel(latSel), .seqLat(seqLat),
    .holdDone(holdDone), .strb(strb), .regRst(regRst), .done(done)
  );
endmodule

// File: tb/sim_rx_rst_seq.sv
`timescale 1ns/1ps
module sim_rx_rst_seq;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rstN, gblRst, seqMode, bypEn, userRdy;
  logic [1:0] feMask, pcsMask;
  logic [4:0] dirRst, compRst;
  logic [3:0] regRst;
  logic done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  rx_rst_seq #(.HOLD_CYCLES(H)) u0 (
    .clk(clk), .rstN(rstN), .gblRst(gblRst), .seqMode(seqMode),
    .feMask(feMask), .pcsMask(pcsMask), .bypEn(bypEn), .userRdy(userRdy),
    .dirRst(dirRst), .regRst(regRst), .compRst(compRst), .done(done)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected {done, regRst} in cycle t after the start edge.
  function automatic logic [4:0] expOut(bit seq, logic [3:0] sel, int t, int u);
    logic [3:0] r = '0;
    logic d = 1'b0;
    int s = 0;
    int e;
    int pcsEnd = (u + 1 > H) ? u + 1 : H;
    if (seq) begin
      for (int k = 0; k < 4; k++) begin
        if (sel[k]) begin
          e = s + H;
          if (k == 3 && u + 1 > e) e = u + 1;
          if (t >= s && t < e) r[k] = 1'b1;
          s = e;
        end
      end
      d = (t >= s);
    end else begin
      for (int k = 0; k < 3; k++) r[k] = sel[k] && (t < H);
      r[3] = sel[3] && (t < pcsEnd);
    end
    return {d, r};
  endfunction

  // Pulse gblRst, apply config, then walk the run; abortAt < 0 runs to the end.
  task automatic runScen(bit seq, logic [1:0] fe, logic [1:0] pc, bit byp,
                         int u, int abortAt, bit scramble);
    logic [3:0] sel = {pc[1], pc[0] & byp, fe[1], fe[0]};
    logic [4:0] ex;
    int n = 4 * H + u + 3;
    gblRst = 1'b1;
    userRdy = 1'b0;
    @(negedge clk);
    chk("R8 regRst during gblRst", 32'(regRst), 0);
    chk("R8 done cleared by gblRst", 32'(done), 0);
    seqMode = seq; feMask = fe; pcsMask = pc; bypEn = byp;
    @(negedge clk);
    gblRst = 1'b0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      ex = expOut(seq, sel, t, u);
      if (seq) chk("R3 R4 R6 R11 sequential regRst", 32'(regRst), 32'(ex[3:0]));
      else     chk("R5 R6 R2 single regRst", 32'(regRst), 32'(ex[3:0]));
      chk("R7 done", 32'(done), 32'(ex[4]));
      chk("R10 compRst", 32'(compRst), seqMode ? 0 : 32'(dirRst));
      if (t == abortAt) return;
      userRdy = (t >= u);
      dirRst = 5'($urandom);
      if (scramble && t == 1) begin  // R9: late config changes ignored
        {seqMode, feMask, pcsMask, bypEn} = 6'($urandom);
      end
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    rstN = 1'b0; gblRst = 1'b0; seqMode = 1'b1; feMask = '0; pcsMask = '0;
    bypEn = 1'b0; userRdy = 1'b0; dirRst = '0;
    repeat (3) @(negedge clk);
    chk("R1 regRst in reset", 32'(regRst), 0);
    chk("R1 done in reset", 32'(done), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 regRst idle after reset", 32'(regRst), 0);
    chk("R1 done idle after reset", 32'(done), 0);

    runScen(1, 2'b11, 2'b11, 1, 0, -1, 0);   // R3 full walk
    runScen(1, 2'b11, 2'b11, 0, 0, -1, 0);   // R11 bypass off
    runScen(1, 2'b10, 2'b01, 1, 0, -1, 0);   // R4 gaps
    runScen(1, 2'b00, 2'b10, 1, 15, -1, 0);  // R6 late userRdy, PCS only
    runScen(1, 2'b00, 2'b00, 1, 0, -1, 0);   // R7 nothing selected
    runScen(0, 2'b11, 2'b11, 1, 0, -1, 0);   // R5 single
    runScen(0, 2'b11, 2'b11, 1, 12, -1, 0);  // R6 single, late userRdy
    runScen(1, 2'b11, 2'b11, 1, 3, 6, 0);    // R8 abort mid-walk
    runScen(1, 2'b11, 2'b11, 1, 0, -1, 1);   // R8 restart, R9 scramble
    for (int i = 0; i < 60; i++) begin
      int u = $urandom_range(0, 20);
      int ab = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 10) : -1;
      runScen(1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
              u, ab, 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      finished = 1;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule